// File: doc/BRIEF.md
# Single-wire pulse-width slave transceiver

This block is the slave-side physical layer of a single-wire, open-drain bus on which each bit signal is a low pulse whose length carries its meaning. It passes the wire through a two-flop synchroniser and counts how many clock cycles the wire stays low. When the wire comes back high, it sorts the interval into one of five events: data 0, data 1, start, attention request or bus reset. It then gives the upper protocol layer a one-cycle strobe with an event code. The wire is also counted while it is high, and a long enough high run marks the bus as inactive.

The block drives the wire through a single pull-down output. A master reads a bit by sending the short pulse. If the upper layer has a 1 to return, the slave extends that pulse by holding the wire low for its own read-1 time; for a 0 it stays off the wire. On request the slave sends an attention pulse, either from an inactive bus or at the falling edge made by another device. This is allowed only after the master has sent a set number of data bits since the last bus reset or power-on. One pin selects which of two device addresses the upper layer uses. All pulse thresholds are parameters counted in clock cycles.

Top module: `pw_slave_phy`

## Requirements
- R1: Each low interval seen on the synchronised wire gives exactly one single-cycle `ev_valid_o` strobe. The strobe comes in the cycle after the synchronised wire returns high. `ev_kind_o` uses the codes 0 = data 0, 1 = data 1, 2 = start, 3 = attention and 4 = bus reset. Both outputs are 0 during reset.
- R2: A low length L below T_BIT1 is a data 0. T_BIT1 <= L < T_START is a data 1.
- R3: T_START <= L < T_ATTN is a start at all times. This holds whatever the read inputs are, and also while attention is locked.
- R4: T_ATTN <= L < T_RESET is an attention. L >= T_RESET is a bus reset. Neither range is ever reported as a data bit or a start.
- R5: If `rd_en_i` and `rd_bit_i` are both 1 when a falling edge is detected, `pull_o` rises in the next cycle and stays high for exactly T_DRV1 cycles. If `rd_bit_i` is 0, `pull_o` stays low.
- R6: With `attn_req_i` high and attention unlocked, the slave starts an attention pulse in one of two cases: the synchronised wire has been high for T_INACT cycles, or a falling edge is being detected. The pulse holds `pull_o` high for exactly T_DRVA cycles. `pull_o` never rises at any other time.
- R7: Attention is locked after `rst_ni` and after every bus-reset event. It unlocks once N_UNLOCK data-bit events have been reported. Start and attention events do not count toward that number.
- R8: If this slave's attention pulse overlaps a master pulse that lasts into the reset range, the event is reported as a bus reset (code 4), not as an attention.
- R9: `dev_addr_o` equals ADDR1 when `addr_sel_i` is 1 and ADDR0 when it is 0.
- R10: The zero bits that follow a bus reset with no start ahead of them are each reported as data 0. Each one counts toward the unlock.
- R11: When an attention start and a read-1 are both due at the same falling edge, the attention wins: the drive lasts T_DRVA cycles and the event is an attention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wire_i | input | 1 | Raw level of the bus wire |
| pull_o | output | 1 | 1 pulls the open-drain wire low |
| addr_sel_i | input | 1 | Picks one of two device addresses |
| dev_addr_o | output | ADDR_W | Selected device address |
| rd_en_i | input | 1 | Current bit is a read by the master |
| rd_bit_i | input | 1 | Value to return on a read |
| attn_req_i | input | 1 | Upper layer wants to send an attention |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_kind_o | output | 3 | Event code (see R1) |

## Verification
An attention launch and a master bit can fall on the same cycle. The bench raises `attn_req_i` two cycles after the master pulls the wire low, so that the attention starts at the same falling edge where a read-1 is also due. A second case starts an attention together with a master bus reset. A behavioural model follows the wire through a history queue and is compared with the design on every clock. Directed checks then confirm that the drive lasted the attention length, that the event was an attention in the first case and a bus reset in the second, and that no data event was reported.

// File: rtl/pw_slave_pkg.sv
package pw_slave_pkg;
  typedef enum logic [2:0] {
    EV_D0    = 3'd0,
    EV_D1    = 3'd1,
    EV_START = 3'd2,
    EV_ATTN  = 3'd3,
    EV_RST   = 3'd4
  } pw_ev_e;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pw_meter.sv
module pw_meter #(
  parameter int CNT_W   = 8,
  parameter int T_RESET = 192,
  parameter int T_INACT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             w_i,
  output logic [CNT_W-1:0] low_len_o,
  output logic             fall_o,
  output logic             seg_end_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] low_q, high_q;

  // both counters saturate so a stuck wire never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (!w_i) begin
      high_q <= '0;
      if (low_q != CNT_W'(T_RESET)) low_q <= low_q + 1'b1;
    end else begin
      low_q <= '0;
      if (high_q != CNT_W'(T_INACT)) high_q <= high_q + 1'b1;
    end
  end

  assign low_len_o = low_q;
  assign fall_o    = !w_i && (low_q == '0);
  assign seg_end_o = w_i && (low_q != '0);
  assign idle_o    = w_i && (high_q == CNT_W'(T_INACT));
endmodule

// File: rtl/pw_gate.sv
module pw_gate #(
  parameter int N_UNLOCK = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_ev_i,
  input  logic reset_ev_i,
  output logic open_o
);
  localparam int GW = $clog2(N_UNLOCK + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (reset_ev_i)          cnt_q <= '0;
    else if (data_ev_i && !open_o) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q == GW'(N_UNLOCK));
endmodule

// File: rtl/pw_driver.sv
module pw_driver #(
  parameter int T_DRV1 = 24,
  parameter int T_DRVA = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic idle_i,
  input  logic open_i,
  input  logic attn_req_i,
  input  logic rd_en_i,
  input  logic rd_bit_i,
  output logic pull_o
);
  localparam int DRV_MAX = (T_DRVA > T_DRV1) ? T_DRVA : T_DRV1;
  localparam int DW      = $clog2(DRV_MAX + 1);
  logic [DW-1:0] left_q;

  // attention outranks read-1: the longer pulse wins on the wire anyway
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      left_q <= '0;
    else if (left_q != '0)                            left_q <= left_q - 1'b1;
    else if (attn_req_i && open_i && (fall_i || idle_i)) left_q <= DW'(T_DRVA);
    else if (fall_i && rd_en_i && rd_bit_i)           left_q <= DW'(T_DRV1);
  end

  assign pull_o = (left_q != '0);
endmodule

// File: rtl/pw_slave_phy.sv
module pw_slave_phy
  import pw_slave_pkg::*;
#(
  parameter int          T_BIT1   = 16,
  parameter int          T_START  = 48,
  parameter int          T_ATTN   = 96,
  parameter int          T_RESET  = 192,
  parameter int          T_INACT  = 8,
  parameter int          T_DRV1   = 24,
  parameter int          T_DRVA   = 128,
  parameter int          N_UNLOCK = 14,
  parameter int          SYNC_N   = 2,
  parameter int          ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] ADDR0 = 3'd2,
  parameter logic [ADDR_W-1:0] ADDR1 = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wire_i,
  output logic              pull_o,
  input  logic              addr_sel_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  input  logic              rd_en_i,
  input  logic              rd_bit_i,
  input  logic              attn_req_i,
  output logic              ev_valid_o,
  output logic [2:0]        ev_kind_o
);
  localparam int CNT_W = $clog2(T_RESET + 1);

  logic             w_s, fall, seg_end, idle, attn_ok;
  logic [CNT_W-1:0] low_len;
  pw_ev_e           kind_c, kind_q;
  logic             ev_q;

  pw_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wire_i), .q_o(w_s)
  );

  pw_meter #(.CNT_W(CNT_W), .T_RESET(T_RESET), .T_INACT(T_INACT)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .w_i(w_s), .low_len_o(low_len),
    .fall_o(fall), .seg_end_o(seg_end), .idle_o(idle)
  );

  // longest range first so long pulses never fall into a shorter class
  always_comb begin
    if      (low_len >= CNT_W'(T_RESET)) kind_c = EV_RST;
    else if (low_len >= CNT_W'(T_ATTN))  kind_c = EV_ATTN;
    else if (low_len >= CNT_W'(T_START)) kind_c = EV_START;
    else if (low_len >= CNT_W'(T_BIT1))  kind_c = EV_D1;
    else                                 kind_c = EV_D0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= 1'b0;
      kind_q <= EV_D0;
    end else begin
      ev_q <= seg_end;
      if (seg_end) kind_q <= kind_c;
    end
  end

  pw_gate #(.N_UNLOCK(N_UNLOCK)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .data_ev_i(ev_q && (kind_q == EV_D0 || kind_q == EV_D1)),
    .reset_ev_i(ev_q && (kind_q == EV_RST)),
    .open_o(attn_ok)
  );

  pw_driver #(.T_DRV1(T_DRV1), .T_DRVA(T_DRVA)) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .idle_i(idle),
    .open_i(attn_ok), .attn_req_i(attn_req_i), .rd_en_i(rd_en_i),
    .rd_bit_i(rd_bit_i), .pull_o(pull_o)
  );

  assign ev_valid_o = ev_q;
  assign ev_kind_o  = kind_q;
  assign dev_addr_o = addr_sel_i ? ADDR1 : ADDR0;
endmodule

// File: rtl/pw_slave_phy_chk.sv
module pw_slave_phy_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pull_o,
  input logic       ev_valid_o,
  input logic [2:0] ev_kind_o,
  input logic       w_s,
  input logic       fall,
  input logic       idle,
  input logic       attn_ok,
  input logic       rd_en_i,
  input logic       rd_bit_i,
  input logic       attn_req_i
);
  p_ev_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |=> !ev_valid_o);

  p_ev_after_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> $past(w_s));

  p_pull_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> $past(fall || idle));

  p_attn_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_o) && !$past(rd_en_i && rd_bit_i)) |-> $past(attn_ok && attn_req_i));

  p_reset_locks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && ev_kind_o == 3'd4) |=> !attn_ok);

  p_read_needs_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_o) && !$past(attn_ok && attn_req_i)) |-> $past(fall && rd_en_i && rd_bit_i));
endmodule

bind pw_slave_phy pw_slave_phy_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pull_o(pull_o), .ev_valid_o(ev_valid_o),
  .ev_kind_o(ev_kind_o), .w_s(w_s), .fall(fall), .idle(idle), .attn_ok(attn_ok),
  .rd_en_i(rd_en_i), .rd_bit_i(rd_bit_i), .attn_req_i(attn_req_i)
);

// File: tb/pw_slave_phy_tb.sv
`timescale 1ns/1ps
module pw_slave_phy_tb;
  localparam int T_BIT1 = 16, T_START = 48, T_ATTN = 96, T_RESET = 192;
  localparam int T_INACT = 8, T_DRV1 = 24, T_DRVA = 128, N_UNLOCK = 14;
  localparam int L0 = 8, L1 = 24, LS = 64, LR = 256;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_low = 1'b0, addr_sel = 1'b0, rd_en = 1'b0, rd_bit = 1'b0, attn_req = 1'b0;
  logic pull_o, ev_valid_o, wire_w;
  logic [2:0] ev_kind_o, dev_addr_o;

  always #4 clk = ~clk;

  assign wire_w = !(m_low || pull_o);

  pw_slave_phy u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wire_i(wire_w), .pull_o(pull_o),
    .addr_sel_i(addr_sel), .dev_addr_o(dev_addr_o), .rd_en_i(rd_en),
    .rd_bit_i(rd_bit), .attn_req_i(attn_req), .ev_valid_o(ev_valid_o),
    .ev_kind_o(ev_kind_o)
  );

  // ---------------- behavioural reference ----------------
  int hist[$];
  int run_low, run_high, unlock, drive_left, m_ev_v, m_ev_k;

  function automatic int kind_of(int n);
    if (n < T_BIT1)  return 0;
    if (n < T_START) return 1;
    if (n < T_ATTN)  return 2;
    if (n < T_RESET) return 3;
    return 4;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{1, 1};
      run_low = 0; run_high = 0; unlock = 0; drive_left = 0; m_ev_v = 0; m_ev_k = 0;
    end else begin
      int w, raw, nv, nk, fallm, idlem;
      raw = (m_low || drive_left > 0) ? 0 : 1;
      hist.push_front(raw);
      w = hist[2];
      void'(hist.pop_back());
      nv = (w == 1 && run_low > 0);
      nk = nv ? kind_of(run_low) : m_ev_k;
      fallm = (w == 0 && run_low == 0);
      idlem = (w == 1 && run_high >= T_INACT);
      if (m_ev_v && m_ev_k == 4) unlock = 0;
      else if (m_ev_v && m_ev_k <= 1 && unlock < N_UNLOCK) unlock++;
      if (drive_left > 0) drive_left--;
      else if (attn_req && unlock_prev_ok() && (fallm || idlem)) drive_left = T_DRVA;
      else if (fallm && rd_en && rd_bit) drive_left = T_DRV1;
      run_low  = w ? 0 : run_low + 1;
      run_high = w ? run_high + 1 : 0;
      m_ev_v = nv; m_ev_k = nk;
    end
  end

  // gate state before this edge's update
  int unlock_seen;
  function automatic bit unlock_prev_ok();
    return unlock_seen == N_UNLOCK;
  endfunction
  always @(negedge clk) unlock_seen = unlock;

  // ---------------- per-cycle comparison and logging ----------------
  int cyc_vec = 0, cyc_bad = 0;
  int ev_k[512];
  int ev_n = 0, rises = 0, pull_cyc = 0;
  logic pull_d = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc_vec++;
      if (pull_o !== (drive_left > 0) || ev_valid_o !== m_ev_v[0] ||
          (m_ev_v != 0 && int'(ev_kind_o) != m_ev_k)) begin
        cyc_bad++;
        $display("FAIL R1/R5/R6 per-cycle model t=%0t pull=%0b/%0b ev=%0b/%0d kind=%0d/%0d",
                 $time, pull_o, drive_left > 0, ev_valid_o, m_ev_v, ev_kind_o, m_ev_k);
      end
      if (ev_valid_o && ev_n < 512) begin ev_k[ev_n] = int'(ev_kind_o); ev_n++; end
      if (pull_o && !pull_d) rises++;
      if (pull_o) pull_cyc++;
      pull_d <= pull_o;
    end
  end

  // ---------------- directed checks ----------------
  int dir_vec = 0, dir_bad = 0, rd_ptr = 0, base_r = 0, base_c = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    dir_vec++;
    if (!ok) begin
      dir_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(int k, string req);
    int a;
    a = (rd_ptr < ev_n) ? ev_k[rd_ptr] : -1;
    if (rd_ptr < ev_n) rd_ptr++;
    chk(a == k, req, a, k);
  endtask

  task automatic expect_no_more(string req);
    chk(rd_ptr == ev_n, req, ev_n - rd_ptr, 0);
  endtask

  task automatic mark();
    base_r = rises; base_c = pull_cyc;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (wire_w && !pull_o) q++; else q = 0;
    end
  endtask

  task automatic pulse(int len);
    m_low = 1'b1;
    repeat (len) @(negedge clk);
    m_low = 1'b0;
    wait_quiet();
  endtask

  task automatic wait_pull(string req);
    int n = 0;
    while (!pull_o && n < 400) begin @(negedge clk); n++; end
    chk(pull_o == 1'b1, req, pull_o, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(pull_o == 0 && ev_valid_o == 0, "R1 reset outputs idle", {pull_o, ev_valid_o}, 0);
    chk(dev_addr_o == 3'd2, "R9 address sel=0", dev_addr_o, 2);
    rst_ni = 1'b1;
    addr_sel = 1'b1;
    @(negedge clk);
    chk(dev_addr_o == 3'd3, "R9 address sel=1", dev_addr_o, 3);
    wait_quiet();

    // bus reset, then training zeros with attention already requested
    pulse(LR);
    expect_ev(4, "R4 long pulse is bus reset");
    attn_req = 1'b1;
    mark();
    for (int i = 0; i < 8; i++) pulse(L0);
    for (int i = 0; i < 8; i++) expect_ev(0, "R10 post-reset zero bit");
    pulse(LS);
    expect_ev(2, "R3 start while locked");
    for (int i = 0; i < 3; i++) pulse(L1);
    for (int i = 0; i < 3; i++) expect_ev(1, "R2 long data pulse is 1");
    for (int i = 0; i < 2; i++) pulse(L0);
    for (int i = 0; i < 2; i++) expect_ev(0, "R2 short data pulse is 0");
    chk(rises == base_r, "R7 locked after 13 data bits, start not counted", rises - base_r, 0);

    // 14th bit unlocks; attention launches from inactive bus
    m_low = 1'b1;
    repeat (L0) @(negedge clk);
    m_low = 1'b0;
    mark();
    wait_pull("R6 attention after unlock");
    attn_req = 1'b0;
    wait_quiet();
    expect_ev(0, "R7 14th data bit");
    expect_ev(3, "R6 own attention reported");
    chk(pull_cyc - base_c == T_DRVA, "R6 attention drive length", pull_cyc - base_c, T_DRVA);
    expect_no_more("R1 one event per interval");

    // read 1 and read 0
    rd_en = 1'b1; rd_bit = 1'b1;
    mark();
    pulse(L0);
    expect_ev(1, "R5 read returns 1");
    chk(pull_cyc - base_c == T_DRV1, "R5 read-1 drive length", pull_cyc - base_c, T_DRV1);
    rd_bit = 1'b0;
    mark();
    pulse(L0);
    expect_ev(0, "R5 read returns 0");
    chk(rises == base_r, "R5 no drive for read 0", rises - base_r, 0);

    // attention and read-1 due at the same falling edge
    rd_bit = 1'b1;
    mark();
    m_low = 1'b1;
    @(negedge clk); @(negedge clk);
    attn_req = 1'b1;
    repeat (L0 - 2) @(negedge clk);
    m_low = 1'b0;
    attn_req = 1'b0;
    wait_quiet();
    expect_ev(3, "R11 attention wins over read-1");
    chk(pull_cyc - base_c == T_DRVA, "R11 drive is attention length", pull_cyc - base_c, T_DRVA);
    expect_no_more("R11 no data event");
    rd_en = 1'b0; rd_bit = 1'b0;

    // attention overlapping a master bus reset
    mark();
    m_low = 1'b1;
    @(negedge clk); @(negedge clk);
    attn_req = 1'b1;
    @(negedge clk);
    attn_req = 1'b0;
    repeat (LR - 3) @(negedge clk);
    m_low = 1'b0;
    wait_quiet();
    expect_ev(4, "R8 attention grown into reset");
    expect_no_more("R8 no attention event");
    chk(rises - base_r == 1, "R8 slave did drive", rises - base_r, 1);

    // relock after bus reset
    attn_req = 1'b1;
    mark();
    for (int i = 0; i < N_UNLOCK - 1; i++) pulse(L0);
    chk(rises == base_r, "R7 relocked after bus reset", rises - base_r, 0);
    m_low = 1'b1;
    repeat (L0) @(negedge clk);
    m_low = 1'b0;
    wait_pull("R7 unlock after 14 bits");
    attn_req = 1'b0;
    wait_quiet();
    for (int i = 0; i < N_UNLOCK; i++) expect_ev(0, "R7 counted data bit");
    expect_ev(3, "R4 attention range");
    expect_no_more("R1 no extra events");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", cyc_vec + dir_vec, cyc_bad + dir_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT && !done) begin
      $display("FAIL watchdog expired actual=%0d expected<%0d", wd, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", cyc_vec + dir_vec + 1,
               cyc_bad + dir_bad + 1);
      $finish;
    end
  end
endmodule